// File: doc/BRIEF.md
# Dual-Channel Serial DAC Input Front End

This block is the digital input side of a two-channel 12-bit converter, modelled synchronously. A host sends 16-bit words over three wires: a serial clock, a data line and an active-low frame strobe. The block runs on a faster system clock and oversamples all of these lines. Each word carries a channel-select bit and a 12-bit code. The code is placed in that channel's input register.

Each channel is double-buffered. While the active-low commit input is held low, the block works in automatic mode and the addressed channel's output latch follows at the end of every word. While commit is held high, words only fill the input registers. A later falling edge on commit copies both input registers into both latches in the same cycle, so the two outputs change together.

A coding input selects how the incoming code is read: twos-complement or offset binary. The latched codes are always presented in offset-binary form, with 0x800 as midscale.

Top module: `dual_dac_frontend`

## Requirements
- R1: A word is exactly 16 bits, sent MSB first. A bit is captured on each falling serial-clock edge seen while the frame strobe is low. Bit falls after the 16th in the same frame are ignored.
- R2: Word bit 12 selects the channel (0 = A, 1 = B). Word bits 11..0 are the code. Word bits 15..13 have no effect.
- R3: With commit held low, the addressed channel's latch takes the new code on the 4th rising system-clock edge after the pin edge that carries the 16th falling serial-clock edge.
- R4: With commit held high, a completed word changes only the input register. Neither output latch changes.
- R5: On the 3rd rising system-clock edge after commit falls, both latches load from their input registers in that one cycle.
- R6: With the coding input high, the code is read as twos-complement and stored with its MSB inverted: 0x7FF gives 0xFFF, 0x000 gives 0x800 and 0x800 gives 0x000.
- R7: With the coding input low, the code is read as offset binary and stored unchanged.
- R8: If the frame strobe rises before 16 bits have arrived, the partial word is discarded and no register changes. The next full frame is received correctly.
- R9: Falling serial-clock edges seen while the frame strobe is high are ignored. The bit count restarts at every falling edge of the frame strobe.
- R10: Synchronous active-low reset sets both latches and both input registers to 0x800 and clears the update pulses.
- R11: A channel's update output is high for exactly the one cycle in which that channel's latch is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the serial lines |
| rst_ni | input | 1 | Synchronous reset, active low |
| ser_clk_i | input | 1 | Serial bit clock; data captured on its falling edge |
| ser_data_i | input | 1 | Serial data, MSB first |
| frame_ni | input | 1 | Word frame strobe, active low |
| commit_ni | input | 1 | Low: automatic latch update; falling edge: load both latches |
| twos_sel_i | input | 1 | 1: twos-complement input codes; 0: offset binary |
| code_a_o | output | 12 | Channel A latched code, offset binary |
| code_b_o | output | 12 | Channel B latched code, offset binary |
| upd_a_o | output | 1 | One-cycle pulse when the channel A latch is loaded |
| upd_b_o | output | 1 | One-cycle pulse when the channel B latch is loaded |

## Verification
A bit counter or shift register that drifts by a single position shows up as a wrong code or a wrong channel on the very next latch load. That is at most four system clocks after the word ends. A stale input register stays hidden in manual mode until the next commit falling edge, and the two latches then disagree with the expected pair in that cycle. For this reason every scenario finishes with a commit or an automatic load. A wrong update pulse, or a latch that changes without its pulse, is visible in the same cycle.

// File: rtl/dacfe_pkg.sv
// Shared constants and helpers for the dual-channel serial DAC front end.
// Assumes a fixed frame layout: channel-select bit directly above the code.
package dacfe_pkg;
    localparam int FRAME_W  = 16;
    localparam int CODE_W   = 12;
    localparam int NUM_CH   = 2;
    localparam int SEL_POS  = CODE_W;          // channel-select bit position
    localparam int PAYLD_W  = CODE_W + 1;      // select bit plus code
    localparam int CNT_W    = $clog2(FRAME_W + 1);

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    // Convert an incoming code to offset binary according to the coding mode.
    function automatic logic [CODE_W-1:0] to_offset_bin(
        input logic [CODE_W-1:0] raw,
        input logic              twos
    );
        return raw ^ {twos, {(CODE_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/dacfe_sync.sv
// Two-flop synchronizer bank for W asynchronous level inputs.
// Assumes each input is held long enough to be seen by at least two clocks.
module dacfe_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    // Capture the raw inputs, then retime them once more.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            meta_q   <= RST_VAL;
            stable_q <= RST_VAL;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;
endmodule

// File: rtl/dacfe_edge.sv
// Falling-edge detector for W already-synchronized signals.
// Assumes inputs come from dacfe_sync with matching reset values.
module dacfe_edge #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level of every input.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= RST_VAL;
        else         prev_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_fall
        assign fall_o[i] = prev_q[i] & ~lvl_i[i];
    end
endmodule

// File: rtl/dacfe_rx.sv
// Frame receiver: counts falling serial-clock edges inside a low frame and
// assembles the channel-select bit and code of a complete word.
// Assumes synchronized levels and single-cycle falling-edge strobes.
// Don't-care bits shift out of the narrow register and are never kept.
module dacfe_rx
    import dacfe_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               frame_s_i,     // synchronized, active low
    input  logic               frame_fall_i,
    input  logic               bclk_fall_i,
    input  logic               data_s_i,
    output logic               word_stb_o,
    output logic [PAYLD_W-1:0] payload_o,
    output logic [CNT_W-1:0]   bit_cnt_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

    logic [CODE_W-1:0] shift_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              capture;

    assign capture = !frame_s_i && bclk_fall_i && (cnt_q < FULL_CNT);

    // Bit counter: restarts on frame start, saturates at a full word.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)           cnt_q <= '0;
        else if (frame_fall_i) cnt_q <= '0;
        else if (capture)      cnt_q <= cnt_q + CNT_W'(1);
    end

    // Shift the incoming bits MSB first, keeping only the newest ones.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      shift_q <= '0;
        else if (capture) shift_q <= {shift_q[CODE_W-2:0], data_s_i};
    end

    // Present the payload with a one-cycle strobe when the last bit lands.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            word_stb_o <= 1'b0;
            payload_o  <= '0;
        end else begin
            word_stb_o <= 1'b0;
            if (!frame_fall_i && capture && cnt_q == LAST_BIT) begin
                word_stb_o <= 1'b1;
                payload_o  <= {shift_q, data_s_i};
            end
        end
    end

    assign bit_cnt_o = cnt_q;
endmodule

// File: rtl/dacfe_chan.sv
// One double-buffered channel: input register plus output latch.
// A new word takes priority over a simultaneous commit transfer.
// Assumes the code arrives already in offset-binary form.
module dacfe_chan #(
    parameter int                 CODE_W = 12,
    parameter logic [CODE_W-1:0]  MID    = {1'b1, {(CODE_W-1){1'b0}}}
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic              auto_i,
    input  logic              xfer_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] lat_o,
    output logic              upd_o
);
    logic [CODE_W-1:0] hold_q;

    // Input register: written by every word addressed to this channel.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   hold_q <= MID;
        else if (wr_i) hold_q <= code_i;
    end

    // Output latch and its one-cycle update pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lat_o <= MID;
            upd_o <= 1'b0;
        end else if (wr_i && auto_i) begin
            lat_o <= code_i;
            upd_o <= 1'b1;
        end else if (xfer_i) begin
            lat_o <= hold_q;
            upd_o <= 1'b1;
        end else begin
            upd_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_dac_frontend.sv
// Top of the dual-channel serial DAC front end. Synchronizes the serial lines,
// receives 16-bit words, converts the code to offset binary and routes it to
// one of two double-buffered channels.
// Assumes each serial-clock level lasts at least two system-clock cycles.
module dual_dac_frontend
    import dacfe_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              frame_ni,
    input  logic              commit_ni,
    input  logic              twos_sel_i,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              upd_a_o,
    output logic              upd_b_o
);
    // Bit positions in the synchronized bundle.
    localparam int I_TWOS   = 0;
    localparam int I_DATA   = 1;
    localparam int I_BCLK   = 2;
    localparam int I_FRAME  = 3;
    localparam int I_COMMIT = 4;
    localparam int N_SYNC   = 5;
    localparam logic [N_SYNC-1:0] SYNC_RST = 5'b11000;
    // Edge bundle: {commit, frame, bclk}.
    localparam int N_EDGE   = 3;
    localparam logic [N_EDGE-1:0] EDGE_RST = SYNC_RST[I_COMMIT:I_BCLK];

    logic [N_SYNC-1:0] raw_in;
    logic [N_SYNC-1:0] sync_lvl;
    logic [N_EDGE-1:0] falls;

    logic               bclk_fall, frame_fall, commit_fall;
    logic               frame_s, commit_s, twos_s, data_s;
    logic               word_stb;
    logic [PAYLD_W-1:0] payload;
    logic [CNT_W-1:0]   bit_cnt;
    logic [CODE_W-1:0]  ob_code;
    logic [CODE_W-1:0]  lat   [NUM_CH];
    logic [NUM_CH-1:0]  upd;

    assign raw_in = {commit_ni, frame_ni, ser_clk_i, ser_data_i, twos_sel_i};

    dacfe_sync #(.W(N_SYNC), .RST_VAL(SYNC_RST)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (raw_in),
        .sync_o  (sync_lvl)
    );

    dacfe_edge #(.W(N_EDGE), .RST_VAL(EDGE_RST)) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (sync_lvl[I_COMMIT:I_BCLK]),
        .fall_o (falls)
    );

    assign bclk_fall   = falls[0];
    assign frame_fall  = falls[1];
    assign commit_fall = falls[2];
    assign frame_s     = sync_lvl[I_FRAME];
    assign commit_s    = sync_lvl[I_COMMIT];
    assign twos_s      = sync_lvl[I_TWOS];
    assign data_s      = sync_lvl[I_DATA];

    dacfe_rx u_rx (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .frame_s_i    (frame_s),
        .frame_fall_i (frame_fall),
        .bclk_fall_i  (bclk_fall),
        .data_s_i     (data_s),
        .word_stb_o   (word_stb),
        .payload_o    (payload),
        .bit_cnt_o    (bit_cnt)
    );

    assign ob_code = to_offset_bin(payload[CODE_W-1:0], twos_s);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic wr_sel;
        assign wr_sel = word_stb && (payload[SEL_POS] == 1'(c));

        dacfe_chan #(.CODE_W(CODE_W)) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .wr_i   (wr_sel),
            .auto_i (!commit_s),
            .xfer_i (commit_fall),
            .code_i (ob_code),
            .lat_o  (lat[c]),
            .upd_o  (upd[c])
        );
    end

    assign code_a_o = lat[CH_A];
    assign code_b_o = lat[CH_B];
    assign upd_a_o  = upd[CH_A];
    assign upd_b_o  = upd[CH_B];
endmodule

// File: rtl/dacfe_checker.sv
// Property checker for dual_dac_frontend, attached by bind below.
// Assumes the default frame layout from dacfe_pkg.
module dacfe_checker
    import dacfe_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [CODE_W-1:0]  code_a,
    input logic [CODE_W-1:0]  code_b,
    input logic               upd_a,
    input logic               upd_b,
    input logic               stb,
    input logic [PAYLD_W-1:0] payload,
    input logic [CNT_W-1:0]   bit_cnt,
    input logic               frame_s,
    input logic               commit_s,
    input logic               twos_s
);
    localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

    // R10: reset drives both latches to midscale and clears the pulses.
    p_reset_mid_r10: assert property (@(posedge clk_i)
        !rst_ni |=> (code_a == MID && code_b == MID && !upd_a && !upd_b));

    // R1: the bit count never passes a full word.
    p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_cnt <= CNT_W'(FRAME_W));

    // R8: a word only completes while the frame is open.
    p_word_in_frame_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stb |-> $past(!frame_s));

    // R4: with commit high and no word, latches hold.
    p_hold_manual_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit_s && !stb) |=> ($stable(code_a) && $stable(code_b)));

    // R3 with R6/R7 conversion: automatic load of channel A.
    p_auto_a_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb && !commit_s && !payload[SEL_POS]) |=>
        code_a == ($past(payload[CODE_W-1:0]) ^ {$past(twos_s), {(CODE_W-1){1'b0}}}));

    // R3 with R6/R7 conversion: automatic load of channel B.
    p_auto_b_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stb && !commit_s && payload[SEL_POS]) |=>
        code_b == ($past(payload[CODE_W-1:0]) ^ {$past(twos_s), {(CODE_W-1){1'b0}}}));

    // R11: a latch never changes without its update pulse.
    p_flag_a_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(code_a) |-> upd_a);
    p_flag_b_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(code_b) |-> upd_b);
endmodule

bind dual_dac_frontend dacfe_checker u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_a   (code_a_o),
    .code_b   (code_b_o),
    .upd_a    (upd_a_o),
    .upd_b    (upd_b_o),
    .stb      (word_stb),
    .payload  (payload),
    .bit_cnt  (bit_cnt),
    .frame_s  (frame_s),
    .commit_s (commit_s),
    .twos_s   (twos_s)
);

// File: tb/tb_dual_dac_frontend.sv
// Self-checking bench: behavioural reference model compared every clock,
// plus directed checks per requirement.
module tb_dual_dac_frontend;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bclk = 1'b1, bdat = 1'b0, frame_n = 1'b1, commit_n = 1'b1, twos = 1'b0;
    logic [11:0] code_a, code_b;
    logic upd_a, upd_b;

    int checks = 0, fails = 0;
    int cnt_upd_a = 0, cnt_upd_b = 0;
    bit cmp_en = 1'b0;
    string cur_req = "R10";

    always #5 clk = ~clk;

    dual_dac_frontend dut (
        .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(bclk), .ser_data_i(bdat),
        .frame_ni(frame_n), .commit_ni(commit_n), .twos_sel_i(twos),
        .code_a_o(code_a), .code_b_o(code_b), .upd_a_o(upd_a), .upd_b_o(upd_b)
    );

    // Reference model state.
    bit q_clk[$], q_dat[$], q_frm[$], q_com[$], q_tw[$];
    int m_a = 'h800, m_b = 'h800, h_a = 'h800, h_b = 'h800;
    bit m_ua = 0, m_ub = 0, m_wv = 0;
    int m_cnt = 0, m_sh = 0, m_word = 0;

    task automatic check(string req, int got, int exp, string what);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Reference model: inputs seen two clocks late, actions on last two samples.
    always @(posedge clk) begin
        if (!rst_n) begin
            q_clk = '{0, 0, 0}; q_dat = '{0, 0, 0}; q_frm = '{1, 1, 1};
            q_com = '{1, 1, 1}; q_tw = '{0, 0, 0};
            m_a = 'h800; m_b = 'h800; h_a = 'h800; h_b = 'h800;
            m_ua = 0; m_ub = 0; m_wv = 0; m_cnt = 0; m_sh = 0; m_word = 0;
        end else begin
            bit nwv;
            int code;
            m_ua = 0; m_ub = 0;
            if (q_com[2] && !q_com[1]) begin
                m_a = h_a; m_b = h_b; m_ua = 1; m_ub = 1;
            end
            if (m_wv) begin
                code = (m_word & 'hFFF) ^ (q_tw[1] ? 'h800 : 0);
                if (((m_word >> 12) & 1) == 0) begin
                    h_a = code;
                    if (!q_com[1]) begin m_a = code; m_ua = 1; end
                end else begin
                    h_b = code;
                    if (!q_com[1]) begin m_b = code; m_ub = 1; end
                end
            end
            nwv = 0;
            if (q_frm[2] && !q_frm[1]) m_cnt = 0;
            else if (!q_frm[1] && q_clk[2] && !q_clk[1] && m_cnt < 16) begin
                m_sh = ((m_sh << 1) | int'(q_dat[1])) & 'hFFFF;
                m_cnt++;
                if (m_cnt == 16) begin nwv = 1; m_word = m_sh; end
            end
            m_wv = nwv;
            q_clk.push_front(bclk);    void'(q_clk.pop_back());
            q_dat.push_front(bdat);    void'(q_dat.pop_back());
            q_frm.push_front(frame_n); void'(q_frm.pop_back());
            q_com.push_front(commit_n); void'(q_com.pop_back());
            q_tw.push_front(twos);     void'(q_tw.pop_back());
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            check(cur_req, int'(code_a), m_a, "model code A");
            check(cur_req, int'(code_b), m_b, "model code B");
            check(cur_req, int'(upd_a), int'(m_ua), "model update A");
            check(cur_req, int'(upd_b), int'(m_ub), "model update B");
        end
        if (upd_a === 1'b1) cnt_upd_a++;
        if (upd_b === 1'b1) cnt_upd_b++;
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Send the n low bits of v, MSB first, inside one frame.
    task automatic send(logic [31:0] v, int n);
        @(negedge clk); frame_n = 1'b0;
        idle(4);
        for (int i = n - 1; i >= 0; i--) begin
            bdat = v[i]; bclk = 1'b1; idle(4);
            bclk = 1'b0; idle(4);
        end
        bclk = 1'b1; idle(2);
        frame_n = 1'b1; idle(8);
    endtask

    task automatic commit_pulse();
        commit_n = 1'b0; idle(6);
        commit_n = 1'b1; idle(6);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin : stim
        int a0, b0;
        idle(2);
        cmp_en = 1'b1;
        idle(3);
        check("R10", int'(code_a), 'h800, "reset code A");
        check("R10", int'(code_b), 'h800, "reset code B");
        check("R10", int'(upd_a) + int'(upd_b), 0, "reset pulses");
        rst_n = 1'b1;
        commit_n = 1'b0;
        idle(6);

        // R1 R3 R7 R11: automatic load, offset binary
        cur_req = "R3";
        a0 = cnt_upd_a; b0 = cnt_upd_b;
        send(32'h0123, 16);
        check("R3", int'(code_a), 'h123, "auto load A");
        check("R7", int'(code_b), 'h800, "B untouched");
        check("R11", cnt_upd_a - a0, 1, "A pulse cycles");
        check("R11", cnt_upd_b - b0, 0, "B pulse cycles");

        // R2: select bit 12, don't-care bits set
        cur_req = "R2";
        send(32'hFABC, 16);
        check("R2", int'(code_b), 'hABC, "select B with junk top bits");
        check("R2", int'(code_a), 'h123, "A kept");

        // R6: twos-complement mapping
        cur_req = "R6";
        twos = 1'b1; idle(6);
        send(32'h07FF, 16);
        check("R6", int'(code_a), 'hFFF, "twos 0x7FF");
        send(32'h1000, 16);
        check("R6", int'(code_b), 'h800, "twos 0x000");
        send(32'h0800, 16);
        check("R6", int'(code_a), 'h000, "twos 0x800");
        twos = 1'b0; idle(6);

        // R4 R5: manual mode then simultaneous commit
        cur_req = "R4";
        commit_n = 1'b1; idle(6);
        send(32'h0111, 16);
        send(32'h1222, 16);
        check("R4", int'(code_a), 'h000, "A held in manual mode");
        check("R4", int'(code_b), 'h800, "B held in manual mode");
        cur_req = "R5";
        a0 = cnt_upd_a; b0 = cnt_upd_b;
        commit_pulse();
        check("R5", int'(code_a), 'h111, "commit A");
        check("R5", int'(code_b), 'h222, "commit B");
        check("R11", cnt_upd_a - a0, 1, "commit pulse A");
        check("R11", cnt_upd_b - b0, 1, "commit pulse B");

        // R8: aborted frame, then a good one
        cur_req = "R8";
        commit_n = 1'b0; idle(6);
        send(32'h1555 >> 6, 10);
        check("R8", int'(code_b), 'h222, "partial word discarded");
        check("R8", int'(code_a), 'h111, "A unchanged by partial");
        send(32'h1555, 16);
        check("R8", int'(code_b), 'h555, "full word after abort");

        // R9: clock edges outside a frame, extra edges inside one
        cur_req = "R9";
        bdat = 1'b1;
        for (int i = 0; i < 5; i++) begin
            bclk = 1'b0; idle(4); bclk = 1'b1; idle(4);
        end
        send(32'h0321, 16);
        check("R9", int'(code_a), 'h321, "idle edges ignored");
        send({16'h0456, 4'hF}, 20);
        check("R1", int'(code_a), 'h456, "edges after 16th ignored");

        idle(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule